// File: doc/BRIEF.md
# Byte-Wide Programming Port for a One-Time-Programmable Array

This block is a parallel access port that lets an external programmer reach a one-time-programmable byte array while the device is held in its programming mode. The programmer presents a 17-bit address and a byte of data, and drives three active-low strobes: chip enable, output enable and program. The block turns these into read and program requests on a simple synchronous array interface. The array returns its data one cycle after a read request. Read data comes back on a separate output with its own drive-enable, so the pad logic outside can build a tri-state bus from it.

The port works only while two strap pins are both low: the device reset pin and the clock pin. At any other time every strobe is ignored and the bus is released. A program operation is a read-modify-write, so stored bits can only go from 1 to 0. Bit 0 of the byte at address 0 acts as a read-protection lock. Once that bit has been programmed to 0, every read returns all ones, whatever the address. All strap, strobe, address and data pins are asynchronous, and the block synchronises them before use.

Top module: `otp_prog_port`

## Requirements
- R1: The port is active only when `strap_rst_i` and `strap_clk_i` are both low. Otherwise program strobes are ignored and `data_oe_o` stays 0.
- R2: All of 0x00000..0x1FFFF can be addressed, and both ends of that range can be read and programmed.
- R3: With chip enable low, output enable low and program high, the port drives `data_oe_o`=1 within 8 clock cycles. `data_o` then equals the byte stored at the address held on `addr_i`.
- R4: `data_oe_o` is 0 whenever chip enable is high, output enable is high, or program is low. It is also 0 after reset.
- R5: Each falling edge of `prog_n_i` performs one program operation on the held address with the held data, provided chip enable is low and the port is active. Each program operation produces exactly one single-cycle array write.
- R6: Programming stores the old byte AND the new byte. Bits that are 0 stay 0, and programming 0xFF leaves a byte unchanged.
- R7: Programming address 0x00000 with bit 0 = 0 (for example 0xFE) sets the lock. From then on every read returns 0xFF at every address.
- R8: The lock takes effect on the first read after the program operation completes. After a synchronous reset the port is unlocked.
- R9: Programming address 0x00000 with bit 0 = 1 (for example 0xFD) does not set the lock. Reads keep returning the stored data.
- R10: A program strobe with chip enable high has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_rst_i | input | 1 | Device reset pin; must be low to enter programming mode |
| strap_clk_i | input | 1 | Clock pin strap; must be low to enter programming mode |
| addr_i | input | 17 | Byte address from the programmer |
| data_i | input | 8 | Data byte to be programmed |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| prog_n_i | input | 1 | Program strobe, active low |
| data_o | output | 8 | Read data toward the pads |
| data_oe_o | output | 1 | Pad drive enable for `data_o` |
| arr_rd_o | output | 1 | Array read request |
| arr_wr_o | output | 1 | Array write request |
| arr_addr_o | output | 17 | Array address |
| arr_wdata_o | output | 8 | Array write data |
| arr_rdata_i | input | 8 | Array read data, valid one cycle after a read request |

## Verification
The lock state and the merge register never appear at the ports directly. Each shows up at the first read that depends on it.

- A lock flag that is set wrongly turns a legitimate read into 0xFF.
- A lock flag that is missing leaves protected data visible on the first read after 0xFE is programmed at address 0.
- A wrong merge shows up as a bit that returns to 1, or a byte that differs from the AND of its history, when that address is next read.

A broken mode gate or read decode shows up as `data_oe_o` asserted within a few cycles of a strobe change that should not drive the bus.

// File: rtl/otp_port_pkg.sv
package otp_port_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_MERGE,
    ST_COMMIT
  } prog_state_t;

  localparam int unsigned NUM_CTRL_PINS = 5;

endpackage

// File: rtl/otp_pin_sync.sv
module otp_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= RST_VAL;
    else     stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= RST_VAL;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/otp_lock_track.sv
module otp_lock_track #(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LOCK_ADDR = 0,
  parameter int unsigned LOCK_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              locked_o
);

  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_ADDR);

  // The written value is already old AND new, so it mirrors the stored byte.
  always_ff @(posedge clk) begin
    if (rst) begin
      locked_o <= 1'b0;
    end else if (wr_en_i && (wr_addr_i == LOCK_A) && !wr_data_i[LOCK_BIT]) begin
      locked_o <= 1'b1;
    end
  end

endmodule

// File: rtl/otp_port_ctrl.sv
module otp_port_ctrl
  import otp_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              prog_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdat_i,
  input  logic              locked_i,
  output logic              arr_rd_o,
  output logic              arr_wr_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);

  prog_state_t       st_q;
  logic              prog_n_prev_q;
  logic [DATA_W-1:0] hold_q;
  logic              rdk_q1, rdk_q2;
  logic              rd_cond, prog_fall, drive;

  assign rd_cond   = active_i && !ce_n_i && !oe_n_i && prog_n_i;
  assign prog_fall = active_i && !ce_n_i && prog_n_prev_q && !prog_n_i;
  assign drive     = rdk_q2 && rd_cond;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      prog_n_prev_q <= 1'b1;
      hold_q        <= '1;
      rdk_q1        <= 1'b0;
      rdk_q2        <= 1'b0;
      arr_rd_o      <= 1'b0;
      arr_wr_o      <= 1'b0;
      arr_addr_o    <= '0;
      arr_wdata_o   <= '1;
      data_o        <= '1;
      data_oe_o     <= 1'b0;
    end else begin
      prog_n_prev_q <= prog_n_i;
      arr_rd_o      <= 1'b0;
      arr_wr_o      <= 1'b0;
      rdk_q1        <= 1'b0;
      rdk_q2        <= rdk_q1;
      data_oe_o     <= drive;
      data_o        <= (drive && !locked_i) ? arr_rdata_i : '1;
      unique case (st_q)
        ST_IDLE: begin
          if (prog_fall) begin
            arr_rd_o   <= 1'b1;
            arr_addr_o <= addr_i;
            hold_q     <= wdat_i;
            st_q       <= ST_FETCH;
          end else if (rd_cond) begin
            arr_rd_o   <= 1'b1;
            arr_addr_o <= addr_i;
            rdk_q1     <= 1'b1;
          end
        end
        ST_FETCH: st_q <= ST_MERGE;
        ST_MERGE: begin
          arr_wr_o    <= 1'b1;
          arr_wdata_o <= arr_rdata_i & hold_q;
          st_q        <= ST_COMMIT;
        end
        ST_COMMIT: st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
  import otp_port_pkg::*;
#(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_rst_i,
  input  logic              strap_clk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              prog_n_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              arr_rd_o,
  output logic              arr_wr_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  input  logic [DATA_W-1:0] arr_rdata_i
);

  localparam int unsigned SYNC_W = NUM_CTRL_PINS + ADDR_W + DATA_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {{NUM_CTRL_PINS{1'b1}}, {(ADDR_W + DATA_W){1'b0}}};

  logic              sy_strap_rst, sy_strap_clk, sy_ce_n, sy_oe_n, sy_prog_n;
  logic [ADDR_W-1:0] sy_addr;
  logic [DATA_W-1:0] sy_data;
  logic              sy_active;
  logic              locked;

  otp_pin_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i({strap_rst_i, strap_clk_i, ce_n_i, oe_n_i, prog_n_i, addr_i, data_i}),
    .q_o({sy_strap_rst, sy_strap_clk, sy_ce_n, sy_oe_n, sy_prog_n, sy_addr, sy_data})
  );

  assign sy_active = !sy_strap_rst && !sy_strap_clk;

  otp_lock_track #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_lock (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (arr_wr_o),
    .wr_addr_i(arr_addr_o),
    .wr_data_i(arr_wdata_o),
    .locked_o (locked)
  );

  otp_port_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .active_i   (sy_active),
    .ce_n_i     (sy_ce_n),
    .oe_n_i     (sy_oe_n),
    .prog_n_i   (sy_prog_n),
    .addr_i     (sy_addr),
    .wdat_i     (sy_data),
    .locked_i   (locked),
    .arr_rd_o   (arr_rd_o),
    .arr_wr_o   (arr_wr_o),
    .arr_addr_o (arr_addr_o),
    .arr_wdata_o(arr_wdata_o),
    .arr_rdata_i(arr_rdata_i),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o)
  );

endmodule

// File: rtl/otp_prog_port_chk.sv
module otp_prog_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              data_oe_o,
  input logic [DATA_W-1:0] data_o,
  input logic              arr_rd_o,
  input logic              arr_wr_o,
  input logic [DATA_W-1:0] arr_wdata_o,
  input logic [DATA_W-1:0] arr_rdata_i,
  input logic              locked,
  input logic              sy_active
);

  a_r1_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
    !sy_active |=> !data_oe_o);

  a_r3_drive_after_read: assert property (@(posedge clk) disable iff (rst)
    data_oe_o |-> $past(arr_rd_o, 2));

  a_r5_write_single_cycle: assert property (@(posedge clk) disable iff (rst)
    arr_wr_o |=> !arr_wr_o);

  a_r5_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(arr_rd_o && arr_wr_o));

  a_r6_only_clears: assert property (@(posedge clk) disable iff (rst)
    arr_wr_o |-> ((arr_wdata_o & ~arr_rdata_i) == '0));

  a_r7_locked_reads_ones: assert property (@(posedge clk) disable iff (rst)
    (data_oe_o && $past(locked)) |-> (data_o == '1));

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(locked) |-> locked);

endmodule

bind otp_prog_port otp_prog_port_chk #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .data_oe_o  (data_oe_o),
  .data_o     (data_o),
  .arr_rd_o   (arr_rd_o),
  .arr_wr_o   (arr_wr_o),
  .arr_wdata_o(arr_wdata_o),
  .arr_rdata_i(arr_rdata_i),
  .locked     (locked),
  .sy_active  (sy_active)
);

// File: tb/test_otp_prog_port.sv
`timescale 1ns/1ps
module test_otp_prog_port;

  localparam int unsigned AW = 17;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strap_rst = 1'b1, strap_clk = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = 8'hFF;
  logic          ce_n = 1'b1, oe_n = 1'b1, prog_n = 1'b1;
  logic [DW-1:0] dout;
  logic          dout_en;
  logic          arr_rd, arr_wr;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;
  logic [DW-1:0] arr_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  otp_prog_port i_otp_prog_port (
    .clk(clk), .rst(rst),
    .strap_rst_i(strap_rst), .strap_clk_i(strap_clk),
    .addr_i(addr), .data_i(din),
    .ce_n_i(ce_n), .oe_n_i(oe_n), .prog_n_i(prog_n),
    .data_o(dout), .data_oe_o(dout_en),
    .arr_rd_o(arr_rd), .arr_wr_o(arr_wr), .arr_addr_o(arr_addr),
    .arr_wdata_o(arr_wdata), .arr_rdata_i(arr_rdata)
  );

  // Array model: one-cycle synchronous read, plain write, erased to 0xFF on reset.
  logic [DW-1:0] mem [logic [AW-1:0]];
  always @(posedge clk) begin
    if (rst) begin
      mem.delete();
      arr_rdata <= 8'hFF;
    end else begin
      if (arr_wr) mem[arr_addr] = arr_wdata;
      if (arr_rd) arr_rdata <= mem.exists(arr_addr) ? mem[arr_addr] : 8'hFF;
    end
  end

  // Expected contents and lock, from the requirements.
  logic [DW-1:0] exp_mem [logic [AW-1:0]];
  bit exp_lock = 1'b0;

  function automatic logic [DW-1:0] exp_byte(input logic [AW-1:0] a);
    if (exp_lock) return 8'hFF;
    return exp_mem.exists(a) ? exp_mem[a] : 8'hFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    exp_mem.delete();
    exp_lock = 1'b0;
    idle(2);
    chk("R4 reset data_oe", 32'(dout_en), 32'd0);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input string tag);
    addr = a;
    ce_n = 1'b0;
    oe_n = 1'b0;
    idle(8);
    chk({tag, " drive"}, 32'(dout_en), 32'd1);
    chk({tag, " data"}, 32'(dout), 32'(exp_byte(a)));
    oe_n = 1'b1;
    idle(6);
    chk("R4 released after oe high", 32'(dout_en), 32'd0);
    ce_n = 1'b1;
    idle(2);
  endtask

  task automatic t_program(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit use_ce);
    addr = a;
    din = d;
    ce_n = !use_ce;
    idle(4);
    prog_n = 1'b0;
    idle(6);
    prog_n = 1'b1;
    idle(4);
    ce_n = 1'b1;
    idle(2);
    if (use_ce && !strap_rst && !strap_clk) begin
      exp_mem[a] = exp_byte_raw(a) & d;
      if (a == '0 && !d[0]) exp_lock = 1'b1;
    end
  endtask

  function automatic logic [DW-1:0] exp_byte_raw(input logic [AW-1:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : 8'hFF;
  endfunction

  task automatic t_mode_gate();
    strap_clk = 1'b1;
    t_program(17'h00005, 8'h00, 1'b1);
    addr = 17'h00005;
    ce_n = 1'b0;
    oe_n = 1'b0;
    idle(8);
    chk("R1 no drive when clock strap high", 32'(dout_en), 32'd0);
    ce_n = 1'b1;
    oe_n = 1'b1;
    strap_clk = 1'b0;
    strap_rst = 1'b1;
    t_program(17'h00006, 8'h00, 1'b1);
    strap_rst = 1'b0;
    idle(4);
    t_read(17'h00005, "R1 program ignored (clk strap)");
    t_read(17'h00006, "R1 program ignored (rst strap)");
  endtask

  task automatic t_ce_gate();
    t_program(17'h00010, 8'h00, 1'b0);
    t_read(17'h00010, "R10 ce high program ignored");
  endtask

  task automatic t_prog_low_no_drive();
    addr = 17'h00040;
    din = 8'hFF;
    ce_n = 1'b0;
    oe_n = 1'b0;
    prog_n = 1'b0;
    idle(8);
    chk("R4 no drive while program low", 32'(dout_en), 32'd0);
    prog_n = 1'b1;
    oe_n = 1'b1;
    ce_n = 1'b1;
    idle(4);
  endtask

  task automatic t_basic_program();
    t_read(17'h00000, "R2 low end erased");
    t_read(17'h1FFFF, "R2 high end erased");
    t_program(17'h00123, 8'hA5, 1'b1);
    t_read(17'h00123, "R5 R3 programmed byte");
    t_program(17'h1FFFF, 8'h81, 1'b1);
    t_read(17'h1FFFF, "R2 high end programmed");
  endtask

  task automatic t_clear_only();
    t_program(17'h00123, 8'h5A, 1'b1);
    t_read(17'h00123, "R6 A5 then 5A gives 00");
    t_program(17'h00125, 8'h3C, 1'b1);
    t_program(17'h00125, 8'hFF, 1'b1);
    t_read(17'h00125, "R6 FF leaves byte unchanged");
    t_program(17'h00126, 8'h0F, 1'b1);
    t_program(17'h00126, 8'hF3, 1'b1);
    t_read(17'h00126, "R6 0F then F3 gives 03");
  endtask

  task automatic t_lock();
    t_program(17'h00000, 8'hFD, 1'b1);
    t_read(17'h00000, "R9 FD at address 0 no lock");
    t_read(17'h00125, "R9 other data still visible");
    t_program(17'h00000, 8'hFE, 1'b1);
    t_read(17'h00125, "R8 first read after lock");
    t_read(17'h00000, "R7 locked address 0");
    t_read(17'h1FFFF, "R7 locked high end");
  endtask

  task automatic t_unlock_reset();
    t_reset();
    t_program(17'h1FFFF, 8'h55, 1'b1);
    t_read(17'h1FFFF, "R8 unlocked after reset");
  endtask

  initial begin
    strap_rst = 1'b0;
    strap_clk = 1'b0;
    t_reset();
    t_basic_program();
    t_clear_only();
    t_mode_gate();
    t_ce_gate();
    t_prog_low_no_drive();
    t_lock();
    t_unlock_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule